// File: doc/BRIEF.md
# Header-Selected Serial Register Access Port

This block is the slave end of a byte-oriented serial control link that lets a host read and write a 256-entry, 8-bit register space. The host frames each transaction with an active-low chip select and clocks bits over a serial clock. It places write bits on the input line and receives read bits on the output line. The first byte of every transaction is a header. The header chooses how the following bytes are read: as address/data pairs, as a burst aimed at one fixed register, or as a read pair followed by write-only pairs. A read can be returned either in a dedicated slot after its address or overlapped with the next incoming byte. One header bit selects which half of the register space the 7-bit addresses land in.

The serial pins are sampled in the system clock domain through short synchronisers. Serial clock edges are found by edge detection, so all logic runs on one clock. The register space itself sits outside the block. It is reached through a plain port with a one-cycle write strobe, a one-cycle read strobe and read data returned in the same cycle.

Top module: `serRegPort`

## Requirements
- R1: A header byte is the first byte of every transaction. Valid headers, with bit 2 cleared, are 0x40, 0x48, 0x43, 0x41 and 0x49, and the same codes with bit 2 set. Any other header causes no register strobe, and `sdoEn` stays low until chip select is deasserted. The next transaction then works normally.
- R2: Header bit 2 is the page bit. Every access goes to `regAddr` = {bit 2 of the header, address byte bits 6..0}.
- R3: Header 0x40 (paired, dedicated read slot): the bytes alternate address, data, address, data. In an address byte, bit 7 = 1 means read and bit 7 = 0 means write. A write stores the next byte. A read returns the register in the next byte slot, and the input bits of that slot are ignored.
- R4: Header 0x48 (paired, overlapped read): after a read address byte, the register is returned while the next byte arrives, and that next byte is taken as the next address byte. Write addresses are followed by a data byte as in R3.
- R5: Header 0x43 (fixed register burst): the first address byte sets direction and register. Every later byte is a write to that register or a fresh read of it, with no address increment.
- R6: Header 0x41: the first address/data pair is a read and every later pair is a write, whatever bit 7 of the address byte holds. Read data uses a dedicated slot.
- R7: Header 0x49: as R6, but the read data is returned while the next byte, a write address, arrives.
- R8: Bits travel MSB first. `sdi` is taken on the rising serial clock edge and `sdo` changes after the falling edge. `sdoEn` is high only during a byte slot that returns read data.
- R9: Raising `csN` in the middle of a byte drops the partial bits, and the next byte after chip select falls again is a header.
- R10: `regWe` and `regRe` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdoEn | output | 1 | High while `sdo` carries read data |
| regAddr | output | 8 | Register address |
| regWe | output | 1 | Register write strobe |
| regWdata | output | 8 | Register write data |
| regRe | output | 1 | Register read strobe |
| regRdata | input | 8 | Register read data, valid in the cycle of `regRe` |

## Verification
The assertions assume that each serial clock level lasts several system clocks, so that every synchronised edge becomes one isolated single-cycle event. They also assume that `sdi` is stable around the rising edge and that chip select changes only while the serial clock is low. The bench holds each serial clock phase for six system clocks and changes `sdi` only while the serial clock is low. It toggles chip select only with the serial clock low, so every strobe the control issues lines up with exactly one completed byte.

// File: rtl/serRegPortPkg.sv
package serRegPortPkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int PAGE_BIT = 2;

  typedef enum logic [2:0] {
    MODE_PAIR_SLOT,
    MODE_PAIR_OVL,
    MODE_FIXED,
    MODE_RDWR_SLOT,
    MODE_RDWR_OVL
  } seqMode_t;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_ADDR,
    ST_DATA,
    ST_DEAD
  } ctlState_t;

  typedef struct packed {
    logic              byteDone;
    logic              csIdle;
    logic [BYTE_W-1:0] rxByte;
  } dpStatus_t;

  typedef struct packed {
    logic              loadTx;
    logic              stopTx;
    logic [BYTE_W-1:0] txByte;
  } dpStrobe_t;
endpackage

// File: rtl/serRegPortDp.sv
module serRegPortDp
  import serRegPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  input  dpStrobe_t stb,
  output dpStatus_t sts,
  output logic      sdo,
  output logic      sdoEn
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csSync, sclkSync, sdiSync;
  logic sclkPrev;
  logic csIdle, sclkNow, sdiBit, rise, fall;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxSr, txSr;
  logic txActive, sdoBit;

  // input synchronisers, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          sdiSync  <= '0;
        end else begin
          csSync   <= {csSync[TOP-1:0], csN};
          sclkSync <= {sclkSync[TOP-1:0], sclk};
          sdiSync  <= {sdiSync[TOP-1:0], sdi};
        end
      end
    end else begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          sdiSync  <= '0;
        end else begin
          csSync   <= csN;
          sclkSync <= sclk;
          sdiSync  <= sdi;
        end
      end
    end
  endgenerate

  assign csIdle  = csSync[TOP];
  assign sclkNow = sclkSync[TOP];
  assign sdiBit  = sdiSync[TOP];
  assign rise    = sclkNow & ~sclkPrev & ~csIdle;
  assign fall    = ~sclkNow & sclkPrev & ~csIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkNow;
  end

  // receive side: MSB first, sampled on rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxSr   <= '0;
    end else if (csIdle) begin
      bitCnt <= '0;
    end else if (rise) begin
      rxSr   <= {rxSr[BYTE_W-2:0], sdiBit};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign sts.byteDone = rise && (bitCnt == BIT_CNT_W'(BYTE_W - 1));
  assign sts.csIdle   = csIdle;
  assign sts.rxByte   = {rxSr[BYTE_W-2:0], sdiBit};

  // transmit side: new bit presented after each falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr     <= '0;
      txActive <= 1'b0;
      sdoBit   <= 1'b0;
    end else if (csIdle) begin
      txActive <= 1'b0;
      sdoBit   <= 1'b0;
    end else if (stb.loadTx) begin
      txSr     <= stb.txByte;
      txActive <= 1'b1;
    end else begin
      if (stb.stopTx) txActive <= 1'b0;
      if (fall) begin
        sdoBit <= txSr[BYTE_W-1];
        txSr   <= {txSr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign sdo   = sdoBit & txActive;
  assign sdoEn = txActive;

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> !sdoEn);
  p_tx_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(stb.loadTx));
  p_sdo_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(fall) && !$past(csIdle)) |-> $stable(sdoBit));
  p_load_on_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |-> sts.byteDone);
endmodule

// File: rtl/serRegPortCtl.sv
module serRegPortCtl
  import serRegPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStatus_t         sts,
  input  logic [BYTE_W-1:0] regRdata,
  output dpStrobe_t         stb,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe
);
  ctlState_t state;
  seqMode_t  mode, hdrMode;
  logic page, dirRd, firstPair, hdrValid;
  logic [BYTE_W-2:0] addrLo;
  logic isRdWr, isOvl, adrRead, fixedRd;
  logic [BYTE_W-1:0] hdrBase;

  assign hdrBase = sts.rxByte & ~(BYTE_W'(1) << PAGE_BIT);

  always_comb begin
    hdrValid = 1'b1;
    hdrMode  = MODE_PAIR_SLOT;
    case (hdrBase)
      8'h40:   hdrMode = MODE_PAIR_SLOT;
      8'h48:   hdrMode = MODE_PAIR_OVL;
      8'h43:   hdrMode = MODE_FIXED;
      8'h41:   hdrMode = MODE_RDWR_SLOT;
      8'h49:   hdrMode = MODE_RDWR_OVL;
      default: hdrValid = 1'b0;
    endcase
  end

  assign isRdWr  = (mode == MODE_RDWR_SLOT) || (mode == MODE_RDWR_OVL);
  assign isOvl   = (mode == MODE_PAIR_OVL) || (mode == MODE_RDWR_OVL);
  assign adrRead = isRdWr ? firstPair : sts.rxByte[BYTE_W-1];
  assign fixedRd = (mode == MODE_FIXED) && dirRd;

  always_comb begin
    stb      = '0;
    regWe    = 1'b0;
    regRe    = 1'b0;
    regWdata = sts.rxByte;
    regAddr  = {page, (state == ST_ADDR) ? sts.rxByte[BYTE_W-2:0] : addrLo};
    stb.txByte = regRdata;
    if (sts.byteDone) begin
      case (state)
        ST_ADDR: begin
          regRe      = adrRead;
          stb.loadTx = adrRead;
          stb.stopTx = !adrRead;
        end
        ST_DATA: begin
          regWe      = !dirRd;
          regRe      = fixedRd;
          stb.loadTx = fixedRd;
          stb.stopTx = !fixedRd;
        end
        default: stb.stopTx = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HDR;
      mode      <= MODE_PAIR_SLOT;
      page      <= 1'b0;
      dirRd     <= 1'b0;
      firstPair <= 1'b0;
      addrLo    <= '0;
    end else if (sts.csIdle) begin
      state     <= ST_HDR;
      firstPair <= 1'b0;
    end else if (sts.byteDone) begin
      case (state)
        ST_HDR: begin
          if (hdrValid) begin
            mode      <= hdrMode;
            page      <= sts.rxByte[PAGE_BIT];
            firstPair <= 1'b1;
            state     <= ST_ADDR;
          end else begin
            state <= ST_DEAD;
          end
        end
        ST_ADDR: begin
          dirRd     <= adrRead;
          addrLo    <= sts.rxByte[BYTE_W-2:0];
          firstPair <= 1'b0;
          state     <= (adrRead && isOvl) ? ST_ADDR : ST_DATA;
        end
        ST_DATA: state <= (mode == MODE_FIXED) ? ST_DATA : ST_ADDR;
        default: state <= ST_DEAD;
      endcase
    end
  end

  p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);
  p_dead_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEAD) |-> (!regWe && !regRe && !stb.loadTx));
  p_hdr_no_access_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR) |-> (!regWe && !regRe));
endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import serRegPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdoEn,
  output logic [7:0] regAddr,
  output logic       regWe,
  output logic [7:0] regWdata,
  output logic       regRe,
  input  logic [7:0] regRdata
);
  dpStatus_t sts;
  dpStrobe_t stb;

  serRegPortDp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .stb(stb), .sts(sts), .sdo(sdo), .sdoEn(sdoEn)
  );

  serRegPortCtl uCtl (
    .clk(clk), .rstN(rstN), .sts(sts), .regRdata(regRdata), .stb(stb),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe)
  );
endmodule

// File: tb/tb_serRegPort.sv
module tb_serRegPort;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NVEC = 7;
  // {header, address byte, data byte, expected}
  localparam logic [31:0] VECS [NVEC] = '{
    32'h40_01_C3_C3, 32'h40_81_00_C3, 32'h44_01_5A_5A, 32'h44_81_00_5A,
    32'h40_81_00_C3, 32'h40_7F_80_80, 32'h44_FF_00_5A
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoEn, regWe, regRe;
  logic [7:0] regAddr, regWdata, regRdata;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, overlapCnt = 0, dblWeCnt = 0, dblReCnt = 0;
  logic prevWe = 1'b0, prevRe = 1'b0;
  logic [7:0] got;
  bit enAll, enAny;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serRegPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdoEn(sdoEn), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata)
  );

  // bench register space, preset to address ^ 0xA5
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
    end
  end
  assign regRdata = mem[regAddr];

  always @(posedge clk) begin
    if (rstN) begin
      if (regWe && regRe) overlapCnt++;
      if (regWe && prevWe) dblWeCnt++;
      if (regRe && prevRe) dblReCnt++;
      prevWe <= regWe;
      prevRe <= regRe;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, output logic [7:0] rx,
                          output bit all, output bit any);
    rx = '0; all = 1; any = 0;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      waitN(HALF);
      sclk = 1'b1;
      rx[i] = sdo;
      all = all & sdoEn;
      any = any | sdoEn;
      waitN(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    logic [7:0] r; bit a, y;
    sendBits(b, 8, r, a, y);
  endtask

  task automatic csStart();
    csN = 1'b0;
    waitN(HALF);
  endtask

  task automatic csEnd();
    waitN(HALF);
    csN = 1'b1;
    waitN(8);
  endtask

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    // reset state
    chk("R8 reset sdoEn", {7'b0, sdoEn}, 8'h00);
    chk("R10 reset strobes", {6'b0, regWe, regRe}, 8'h00);

    // table of single-pair transactions (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] h, a, d, e;
      {h, a, d, e} = VECS[v];
      csStart();
      sendByte(h);
      sendByte(a);
      sendBits(d, 8, got, enAll, enAny);
      csEnd();
      if (a[7]) begin
        chk("R3 R2 read data", got, e);
        chk("R8 sdoEn in read slot", {7'b0, enAll}, 8'h01);
      end else begin
        chk("R3 R2 written value", mem[{h[2], a[6:0]}], e);
        chk("R8 sdoEn low in write slot", {7'b0, enAny}, 8'h00);
      end
    end
    chk("R2 lower page kept", mem[8'h01], 8'hC3);

    // R3: several pairs in one transaction, MSB first
    csStart();
    sendByte(8'h40); sendByte(8'h12); sendByte(8'h3C);
    sendBits(8'h92, 8, got, enAll, enAny);
    chk("R8 sdoEn low in address slot", {7'b0, enAny}, 8'h00);
    sendBits(8'hFF, 8, got, enAll, enAny);
    csEnd();
    chk("R3 multi-pair read", got, 8'h3C);
    chk("R3 read slot input ignored", mem[8'h12], 8'h3C);

    // R4: overlapped reads
    csStart();
    sendByte(8'h48); sendByte(8'hA0);
    sendBits(8'hA1, 8, got, enAll, enAny);
    chk("R4 overlapped read 0x20", got, 8'h85);
    chk("R4 sdoEn during overlap", {7'b0, enAll}, 8'h01);
    sendBits(8'h30, 8, got, enAll, enAny);
    chk("R4 overlapped read 0x21", got, 8'h84);
    sendBits(8'h99, 8, got, enAll, enAny);
    chk("R4 sdoEn low in write data", {7'b0, enAny}, 8'h00);
    csEnd();
    chk("R4 write after overlap", mem[8'h30], 8'h99);

    // R5: fixed register burst, write then read
    csStart();
    sendByte(8'h43); sendByte(8'h10);
    sendByte(8'h01); sendByte(8'h02); sendByte(8'h03);
    csEnd();
    chk("R5 burst write last", mem[8'h10], 8'h03);
    chk("R5 no increment", mem[8'h11], 8'hB4);
    csStart();
    sendByte(8'h43); sendByte(8'h90);
    for (int k = 0; k < 3; k++) begin
      sendBits(8'hFF, 8, got, enAll, enAny);
      chk("R5 burst read", got, 8'h03);
    end
    csEnd();
    chk("R5 read burst no write", mem[8'h10], 8'h03);

    // R6: read pair then forced writes, dedicated slot
    csStart();
    sendByte(8'h41); sendByte(8'h08);
    sendBits(8'hEE, 8, got, enAll, enAny);
    chk("R6 forced read", got, 8'hAD);
    sendByte(8'h89); sendByte(8'h55);
    csEnd();
    chk("R6 read target unchanged", mem[8'h08], 8'hAD);
    chk("R6 forced write", mem[8'h09], 8'h55);

    // R7: read overlapped with write address
    csStart();
    sendByte(8'h49); sendByte(8'h0A);
    sendBits(8'h8B, 8, got, enAll, enAny);
    chk("R7 overlapped first read", got, 8'hAF);
    sendByte(8'h66);
    csEnd();
    chk("R7 forced write", mem[8'h0B], 8'h66);
    chk("R7 read target unchanged", mem[8'h0A], 8'hAF);

    // R1: unknown header
    csStart();
    sendByte(8'h42);
    sendBits(8'h11, 8, got, enAll, enAny);
    chk("R1 sdoEn low after bad header", {7'b0, enAny}, 8'h00);
    sendByte(8'h22);
    sendBits(8'h91, 8, got, enAll, enAny);
    chk("R1 sdoEn low after bad header", {7'b0, enAny}, 8'h00);
    csEnd();
    chk("R1 no write after bad header", mem[8'h11], 8'hB4);
    csStart();
    sendByte(8'h40); sendByte(8'h11); sendByte(8'h22);
    csEnd();
    chk("R1 recovery", mem[8'h11], 8'h22);

    // R9: abort mid-byte
    csStart();
    sendByte(8'h40);
    sendBits(8'h13, 5, got, enAll, enAny);
    csEnd();
    chk("R9 aborted byte no write", mem[8'h13], 8'hB6);
    csStart();
    sendByte(8'h40); sendByte(8'h13); sendByte(8'h44);
    csEnd();
    chk("R9 header after abort", mem[8'h13], 8'h44);

    // R10: strobe shape over the whole run
    chk("R10 we/re overlap", 8'(overlapCnt), 8'h00);
    chk("R10 we pulse width", 8'(dblWeCnt), 8'h00);
    chk("R10 re pulse width", 8'(dblReCnt), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule